// File: doc/BRIEF.md
# USB Serial Receive State Machine

This block sits between a recovered USB line-bit stream and a serial interface engine. It watches the line level and a single-ended-zero indication, undoes NRZI coding, and hunts for the SYNC pattern. Once SYNC is found it raises receive-active, drops the zeros that the transmitter inserted after runs of six ones, and packs the remaining bits into bytes, least significant bit first. Each completed byte is presented on the data output with a one-clock valid pulse. The packet ends on a single-ended zero or on a bit-stuff violation. A violation is reported as an error only at full speed; at high speed it is treated as the end of the packet.

A speed-select input sets the sampling rate. At high speed the line is sampled on every clock. At full speed it is sampled once every five clocks by a divider that restarts at reset. After each packet, receive-active is held low for a minimum number of clocks, which depends on the speed, before the block looks for SYNC again.

Top module: `usb_rx_fsm`

## Requirements
- R1: After reset, rx_active, rx_valid and rx_error are 0 and rx_data is 0x00.
- R2: The line is NRZI decoded: an unchanged level is a 1 and a change is a 0. A decoded run of at least three 0s followed by a 1 is SYNC. rx_active rises after SYNC, and the bytes that follow are assembled LSB first.
- R3: A decoded 0 that follows six consecutive 1s is removed from the data. The final 1 of SYNC counts toward that run.
- R4: At full speed, a seventh consecutive 1 pulses rx_error for one clock, drops rx_active, and produces no further valid byte.
- R5: At high speed, a seventh consecutive 1 ends the packet (rx_active falls) without asserting rx_error.
- R6: rx_valid is high only while rx_active is high, for exactly one clock per received byte. At full speed it is never high on two consecutive clocks.
- R7: When line_se0 is seen while rx_active is high, rx_active is low on the next clock edge. A partial byte (fewer than 8 bits) is discarded without a valid pulse.
- R8: On the clock after rx_error is high, rx_valid is low.
- R9: Between packets, rx_active stays low for at least 1 clock at high speed and at least 4 clocks at full speed.
- R10: With fs_mode = 1, the line is sampled once per 5 clocks, so bits held for 5 clocks are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_mode | input | 1 | 1 = full speed (bit every 5 clocks), 0 = high speed |
| line_bit | input | 1 | Differential line level, 1 = J |
| line_se0 | input | 1 | Single-ended zero on the line |
| rx_active | output | 1 | Packet in progress |
| rx_valid | output | 1 | rx_data holds a new byte (one clock) |
| rx_error | output | 1 | Bit-stuff error at full speed (one clock) |
| rx_data | output | 8 | Received byte |

## Verification
The hardest states to reach are the bit-stuff boundaries. These are a byte made only of ones, which makes stuffed zeros pile up until a byte time passes with no valid pulse, and a deliberate run of seven ones. The bench builds packets from decoded bits and inserts stuffed zeros arithmetically. It then appends an unstuffed run of ones after a 0, so the violation falls inside a partial byte. Each packet shape is swept at both speeds, and one packet per speed carries every byte value from 0 to 255.

// File: rtl/usb_rx_fsm.sv
module usb_rx_fsm #(
  parameter int FS_DIV     = 5,
  parameter int HS_GAP     = 1,
  parameter int FS_GAP     = 4,
  parameter int SYNC_ZEROS = 3,
  parameter int STUFF_RUN  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_mode,
  input  logic       line_bit,
  input  logic       line_se0,
  output logic       rx_active,
  output logic       rx_valid,
  output logic       rx_error,
  output logic [7:0] rx_data
);

  localparam int DIV_W = $clog2(FS_DIV + 1);
  localparam int GAP_M = (FS_GAP > HS_GAP) ? FS_GAP : HS_GAP;
  localparam int GAP_W = $clog2(GAP_M + 1);
  localparam int ZR_W  = $clog2(SYNC_ZEROS + 1);
  localparam int RUN_W = $clog2(STUFF_RUN + 2);

  typedef enum logic [1:0] {S_WAIT, S_DATA, S_GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [ZR_W-1:0]  zero_run;
  logic [RUN_W-1:0] ones;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic             prev_lvl;

  logic strobe, dbit, stuff_hit, stuff_err, byte_done, sync_hit;
  logic [GAP_W-1:0] gap_load;

  assign strobe    = !fs_mode || (div_cnt == DIV_W'(FS_DIV - 1));
  assign dbit      = (line_bit == prev_lvl);
  assign stuff_hit = (ones == RUN_W'(STUFF_RUN));
  assign stuff_err = strobe && stuff_hit && dbit;
  assign byte_done = strobe && !stuff_hit && (bit_cnt == 3'd7);
  assign sync_hit  = strobe && dbit && (zero_run == ZR_W'(SYNC_ZEROS));
  assign gap_load  = fs_mode ? GAP_W'(FS_GAP - 1) : GAP_W'(HS_GAP - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else if (!fs_mode || strobe) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_lvl <= 1'b1;
    else if (line_se0) prev_lvl <= 1'b1;
    else if (strobe) prev_lvl <= line_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      rx_active <= 1'b0;
      rx_valid  <= 1'b0;
      rx_error  <= 1'b0;
      rx_data   <= '0;
      gap_cnt   <= '0;
      zero_run  <= '0;
      ones      <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      case (st)
        S_WAIT: begin
          if (line_se0) zero_run <= '0;
          else if (strobe) begin
            if (!dbit) begin
              if (zero_run != ZR_W'(SYNC_ZEROS)) zero_run <= zero_run + 1'b1;
            end else zero_run <= '0;
            if (sync_hit) begin
              st        <= S_DATA;
              rx_active <= 1'b1;
              ones      <= RUN_W'(1);
              bit_cnt   <= '0;
            end
          end
        end
        S_DATA: begin
          if (line_se0 || stuff_err) begin
            st        <= S_GAP;
            rx_active <= 1'b0;
            rx_error  <= stuff_err && !line_se0 && fs_mode;
            gap_cnt   <= gap_load;
            zero_run  <= '0;
          end else if (strobe) begin
            if (stuff_hit) ones <= '0;
            else begin
              ones    <= dbit ? ones + 1'b1 : '0;
              shreg   <= {dbit, shreg[7:1]};
              bit_cnt <= bit_cnt + 1'b1;
              if (byte_done) begin
                rx_data  <= {dbit, shreg[7:1]};
                rx_valid <= 1'b1;
              end
            end
          end
        end
        default: begin
          zero_run <= '0;
          if (gap_cnt == '0) st <= S_WAIT;
          else gap_cnt <= gap_cnt - 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_rx_fsm_chk.sv
module usb_rx_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fs_mode,
  input logic       line_se0,
  input logic       rx_active,
  input logic       rx_valid,
  input logic       rx_error,
  input logic [7:0] rx_data
);

  p_valid_in_pkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

  p_fs_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_mode && rx_valid) |=> !rx_valid);

  p_err_drops_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_valid);

  p_err_fs_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> (fs_mode && !rx_active));

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error);

  p_se0_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && line_se0) |=> !rx_active);

  p_fs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_mode && $fell(rx_active)) |=> !rx_active ##1 !rx_active ##1 !rx_active);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data) || $past(!rst_n));

endmodule

bind usb_rx_fsm usb_rx_fsm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .line_se0(line_se0),
  .rx_active(rx_active), .rx_valid(rx_valid), .rx_error(rx_error), .rx_data(rx_data)
);

// File: tb/usb_rx_fsm_tb.sv
module usb_rx_fsm_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, fs_mode = 1'b0, line_bit = 1'b1, line_se0 = 1'b0;
  logic rx_active, rx_valid, rx_error;
  logic [7:0] rx_data;

  usb_rx_fsm u_dut (.clk(clk), .rst_n(rst_n), .fs_mode(fs_mode), .line_bit(line_bit),
    .line_se0(line_se0), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_error(rx_error), .rx_data(rx_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tx_buf [0:299];
  logic [7:0] rcv [0:299];
  int rcv_n = 0, err_n = 0, low_run = 0;
  bit prev_act = 0, prev_val = 0, prev_err = 0, seen_fall = 0, done = 0;
  logic lvl = 1'b1;
  int ones = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rx_valid) begin
        chk(rx_active, "R6 valid outside packet", 0, 1);
        if (fs_mode) chk(!prev_val, "R6 fs valid two clocks", 1, 0);
        if (rcv_n < 300) rcv[rcv_n] = rx_data;
        rcv_n++;
      end
      if (prev_err) chk(!rx_valid, "R8 valid after error", int'(rx_valid), 0);
      if (rx_error) err_n++;
      if (line_se0 && prev_act) chk(!rx_active, "R7 se0 end", int'(rx_active), 0);
      if (prev_act && !rx_active) begin seen_fall = 1; low_run = 0; end
      if (!rx_active) low_run++;
      if (!prev_act && rx_active && seen_fall)
        chk(low_run >= (fs_mode ? 4 : 1), "R9 gap", low_run, fs_mode ? 4 : 1);
      prev_act = rx_active; prev_val = rx_valid; prev_err = rx_error;
    end
  end

  task automatic drive(input logic b, input logic se0);
    @(negedge clk);
    line_bit = b; line_se0 = se0;
    repeat ((fs_mode ? 5 : 1) - 1) @(negedge clk);
  endtask

  task automatic send_dec(input logic b);
    if (!b) lvl = ~lvl;
    drive(lvl, 1'b0);
  endtask

  task automatic send_stuffed(input logic b);
    send_dec(b);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin send_dec(1'b0); ones = 0; end
  endtask

  // mode 0: normal, 1: three extra bits before EOP, 2: seven-ones violation
  task automatic pkt(input bit fs, input int n, input int mode, input string tag);
    fs_mode = fs;
    lvl = 1'b1;
    repeat (4) drive(1'b1, 1'b0);
    rcv_n = 0; err_n = 0;
    for (int i = 0; i < 7; i++) send_dec(1'b0);
    send_dec(1'b1);
    ones = 1;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) send_stuffed(tx_buf[i][k]);
    if (mode == 1) begin send_stuffed(1'b1); send_stuffed(1'b0); send_stuffed(1'b1); end
    if (mode == 2) begin
      send_dec(1'b0);
      for (int k = 0; k < 7; k++) send_dec(1'b1);
      repeat (4) send_dec(1'b1);
    end
    repeat (2) drive(1'b0, 1'b1);
    lvl = 1'b1;
    repeat (8) drive(1'b1, 1'b0);
    chk(rcv_n == n, {tag, " byte count"}, rcv_n, n);
    for (int i = 0; i < n && i < rcv_n; i++)
      chk(rcv[i] == tx_buf[i], {tag, " byte value"}, int'(rcv[i]), int'(tx_buf[i]));
    chk(err_n == ((mode == 2 && fs) ? 1 : 0), {tag, " error pulses"}, err_n,
        (mode == 2 && fs) ? 1 : 0);
    chk(!rx_active, {tag, " idle after packet"}, int'(rx_active), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rx_active && !rx_valid && !rx_error && rx_data == 8'h00, "R1 reset outputs",
        int'({rx_active, rx_valid, rx_error}), 0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      bit fs = (s == 1);
      for (int i = 0; i < 256; i++) tx_buf[i] = 8'(i);
      pkt(fs, 256, 0, fs ? "R2 R10 fs sweep" : "R2 hs sweep");
      for (int i = 0; i < 9; i++) tx_buf[i] = 8'hFF;
      pkt(fs, 9, 0, "R3 stuffed ones");
      for (int i = 0; i < 5; i++) tx_buf[i] = 8'(i * 37 + 5);
      pkt(fs, 5, 1, "R7 partial byte");
      tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'h56;
      pkt(fs, 3, 2, fs ? "R4 fs stuff error" : "R5 hs stuff error");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule